// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

The block translates 32-bit virtual addresses into physical addresses using a small, fully associative set of cached mappings. Each mapping is keyed by a virtual page number and by the process identifier that owned the context at install time. A lookup that finds its key returns a physical address one cycle later. That address is the stored frame number with the untouched page offset appended. The block also checks the read, write and execute rights of the mapping. Each successful access records that the page was referenced and, for a write, that it was modified.

A lookup that finds no key stops taking new requests. It raises a walk request that carries the page number and process identifier. An external table walker, which owns the page table base and the table format, answers with one fill beat. A fill marked present goes into the slot named by a round-robin pointer, and the held access is answered from that fill. A fill marked absent is answered as a page fault and nothing is written.

On a context switch, software can either load a new process identifier or clear every mapping at once. Loading a new identifier leaves the mappings of other processes resident.

Top module: `xlat_tlb`

## Requirements
- R1: The physical address returned for a permitted access is the 20-bit frame number in bits 31:12 and the request's 12-bit offset (virtual address bits 11:0) unchanged in bits 11:0.
- R2: A request accepted while `req_ready` is high that matches a resident mapping returns `rsp_valid` on the next cycle and raises no walk request.
- R3: A request that matches nothing raises `walk_req_valid` on the next cycle, with `walk_vpn` equal to virtual address bits 31:12 and `walk_pid` equal to the current process register. Walk request, page number and identifier are held, and `req_ready` stays low, until a cycle with `fill_valid` high.
- R4: A fill with `fill_present` high is installed and answered one cycle later with `rsp_valid`. The walk request drops in that cycle, and a later access to the same page and process hits.
- R5: A fill with `fill_present` low answers with `rsp_fault` high and address zero, and installs nothing: repeating the access raises a new walk.
- R6: Access kind `req_kind` encodes 0 read, 1 write, 2 or 3 execute. The access needs the mapping's read, write or execute right respectively. Without it, `rsp_perm` is high, the address is zero, and the referenced and modified bits are unchanged.
- R7: A mapping hits only when its tag equals the process register. `pid_load` writes `pid_value` into that register at the clock edge. Mappings of other processes stay resident across the change.
- R8: `flush_all` invalidates every mapping in one cycle. A request accepted in the same cycle is handled as a miss.
- R9: Installs go to slots in round-robin order, so after eight installs with no flush in between, a ninth install evicts the first of the eight.
- R10: A permitted access sets the mapping's referenced bit, and a permitted write also sets its modified bit. `rsp_upd_ref` and `rsp_upd_mod` are high when that access changed the bit from clear to set.
- R11: `rsp_nocache` carries the caching-disabled bit of the mapping on a permitted access.
- R12: After reset the process register is 0, no mapping is valid, `req_ready` is high, and `rsp_valid` and `walk_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pid_load | input | 1 | Load the current process register |
| pid_value | input | 6 | New process identifier |
| flush_all | input | 1 | Invalidate every mapping |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2/3 execute |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address, zero on any fault |
| rsp_fault | output | 1 | Page fault (mapping not present) |
| rsp_perm | output | 1 | Protection violation |
| rsp_nocache | output | 1 | Caching-disabled bit of the mapping |
| rsp_upd_ref | output | 1 | Referenced bit changed from clear to set |
| rsp_upd_mod | output | 1 | Modified bit changed from clear to set |
| walk_req_valid | output | 1 | Request to the table walker |
| walk_vpn | output | 20 | Page number to walk |
| walk_pid | output | 6 | Process identifier to walk |
| fill_valid | input | 1 | Walker answer beat |
| fill_present | input | 1 | Mapping present |
| fill_pfn | input | 20 | Frame number |
| fill_rd | input | 1 | Read right |
| fill_wr | input | 1 | Write right |
| fill_ex | input | 1 | Execute right |
| fill_nc | input | 1 | Caching disabled |
| fill_ref | input | 1 | Referenced bit from the table |
| fill_mod | input | 1 | Modified bit from the table |

## Verification
Some properties are checked on every cycle: at most one slot matches a key, a flush leaves no valid slot, and the victim pointer moves by exactly one slot per install. The walk request is also held stable until the fill, each fill and each clean hit produces a response the next cycle, and faulting responses carry no address and no bit updates. The outcome of a translation can only be shown by the directed scenarios. These cover the address concatenation, which accesses hit after a context switch, eviction order, and whether referenced and modified bits were already set.

// File: rtl/xlat_pkg.sv
// Shared types for the translation buffer.
// Assumes: flag layout is used identically by storage, checker and top.
package xlat_pkg;

    // Control bits kept with every mapping.
    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic nc;
        logic refd;
        logic dirty;
    } pte_flags_t;

    // Lookup sequencer states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } xlat_state_t;

endpackage

// File: rtl/xlat_access_check.sv
// Rights check and bit update for one access.
// Decides whether the access kind is allowed by the mapping's rights and
// computes the updated referenced/modified bits.
// Assumes: kind 0 read, 1 write, 2/3 execute.
module xlat_access_check
    import xlat_pkg::*;
(
    input  logic [1:0]  kind,
    input  pte_flags_t  flags_in,
    output logic        allow,
    output logic        set_ref,
    output logic        set_mod,
    output pte_flags_t  flags_out
);

    logic is_write;
    logic is_exec;

    // Decode the access kind.
    always_comb begin
        is_exec  = kind[1];
        is_write = !kind[1] && kind[0];
    end

    // Rights check and referenced/modified update.
    always_comb begin
        if (is_exec)       allow = flags_in.ex;
        else if (is_write) allow = flags_in.wr;
        else               allow = flags_in.rd;
        set_ref              = allow && !flags_in.refd;
        set_mod              = allow && is_write && !flags_in.dirty;
        flags_out            = flags_in;
        flags_out.refd       = flags_in.refd  | allow;
        flags_out.dirty      = flags_in.dirty | (allow && is_write);
    end

endmodule

// File: rtl/xlat_victim.sv
// Round-robin victim pointer.
// Advances one slot per install and wraps after the last slot.
// Assumes: adv is only high on cycles that really write a slot.
module xlat_victim #(
    parameter int N = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] ptr
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] ptr_q;

    // Step the pointer on each install.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= '0;
        else if (adv)        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign ptr = ptr_q;

    // R9
    victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ((ptr == '0) || (ptr == $past(ptr) + 1'b1)) && (ptr != $past(ptr) || N == 1));

    // R9
    victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));

endmodule

// File: rtl/xlat_tag_array.sv
// Fully associative mapping store.
// Holds N slots of {valid, pid, vpn, pfn, flags}; compares all slots
// against a lookup key in parallel and reports a single hit.
// Assumes: install and update never target a slot in the same cycle
// except through flush priority; flush clears valid bits only.
module xlat_tag_array
    import xlat_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int PID_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [PID_W-1:0]     lk_pid,
    output logic                 hit,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] hit_idx,
    output logic [PFN_W-1:0]     hit_pfn,
    output pte_flags_t           hit_flags,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic [((N > 1) ? $clog2(N) : 1)-1:0] wr_idx,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  logic [PID_W-1:0]     wr_pid,
    input  logic [PFN_W-1:0]     wr_pfn,
    input  pte_flags_t           wr_flags,
    input  logic                 upd_en,
    input  logic [((N > 1) ? $clog2(N) : 1)-1:0] upd_idx,
    input  pte_flags_t           upd_flags
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     valid_vec;
    logic [N-1:0]     match;
    logic [PFN_W-1:0] slot_pfn   [N];
    pte_flags_t       slot_flags [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic             v_q;
        logic [VPN_W-1:0] vpn_q;
        logic [PID_W-1:0] pid_q;
        logic [PFN_W-1:0] pfn_q;
        pte_flags_t       flg_q;

        // Slot storage: flush, then install, then bit update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q   <= 1'b0;
                vpn_q <= '0;
                pid_q <= '0;
                pfn_q <= '0;
                flg_q <= '0;
            end else if (flush) begin
                v_q   <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                v_q   <= 1'b1;
                vpn_q <= wr_vpn;
                pid_q <= wr_pid;
                pfn_q <= wr_pfn;
                flg_q <= wr_flags;
            end else if (upd_en && upd_idx == IDX_W'(i)) begin
                flg_q <= upd_flags;
            end
        end

        assign valid_vec[i]  = v_q;
        assign match[i]      = v_q && (vpn_q == lk_vpn) && (pid_q == lk_pid);
        assign slot_pfn[i]   = pfn_q;
        assign slot_flags[i] = flg_q;
    end

    // Encode the matching slot and select its contents.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
        hit       = |match;
        hit_pfn   = slot_pfn[hit_idx];
        hit_flags = slot_flags[hit_idx];
    end

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/xlat_tlb.sv
// Process-tagged translation buffer with walk request.
// Looks up {vpn, current pid}; a hit answers next cycle, a miss stalls
// and asks an external walker, whose fill is installed round-robin.
// Assumes: the walker answers each walk request with exactly one
// fill_valid beat; requesters hold their request until req_ready.
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    parameter int PID_W   = 6,
    parameter int ENTRIES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pid_load,
    input  logic [PID_W-1:0]        pid_value,
    input  logic                    flush_all,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic [1:0]              req_kind,
    output logic                    rsp_valid,
    output logic [PFN_W+OFF_W-1:0]  rsp_paddr,
    output logic                    rsp_fault,
    output logic                    rsp_perm,
    output logic                    rsp_nocache,
    output logic                    rsp_upd_ref,
    output logic                    rsp_upd_mod,
    output logic                    walk_req_valid,
    output logic [VA_W-OFF_W-1:0]   walk_vpn,
    output logic [PID_W-1:0]        walk_pid,
    input  logic                    fill_valid,
    input  logic                    fill_present,
    input  logic [PFN_W-1:0]        fill_pfn,
    input  logic                    fill_rd,
    input  logic                    fill_wr,
    input  logic                    fill_ex,
    input  logic                    fill_nc,
    input  logic                    fill_ref,
    input  logic                    fill_mod
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    xlat_state_t       state_q;
    logic [PID_W-1:0]  pid_q;
    logic [VPN_W-1:0]  h_vpn;
    logic [OFF_W-1:0]  h_off;
    logic [1:0]        h_kind;
    logic [PID_W-1:0]  h_pid;

    logic              fire, hit_eff, miss_go, fill_take, install;
    logic              tag_hit;
    logic [IDX_W-1:0]  tag_idx, vic_ptr;
    logic [PFN_W-1:0]  tag_pfn;
    pte_flags_t        tag_flags, fill_flags, chk_in, chk_out;
    logic [1:0]        chk_kind;
    logic              allow, set_ref, set_mod;

    // Handshake and path selection.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        fire      = req_valid && req_ready;
        hit_eff   = fire && tag_hit && !flush_all;
        miss_go   = fire && !(tag_hit && !flush_all);
        fill_take = (state_q == ST_WALK) && fill_valid;
        install   = fill_take && fill_present && !flush_all;
        fill_flags = '{rd: fill_rd, wr: fill_wr, ex: fill_ex, nc: fill_nc,
                       refd: fill_ref, dirty: fill_mod};
        chk_in    = fill_take ? fill_flags : tag_flags;
        chk_kind  = fill_take ? h_kind     : req_kind;
    end

    // Current process register.
    always_ff @(posedge clk) begin
        if (!rst_n)        pid_q <= '0;
        else if (pid_load) pid_q <= pid_value;
    end

    // Lookup sequencer: idle, or waiting for the walker.
    always_ff @(posedge clk) begin
        if (!rst_n)                             state_q <= ST_IDLE;
        else if (state_q == ST_IDLE && miss_go) state_q <= ST_WALK;
        else if (fill_take)                     state_q <= ST_IDLE;
    end

    // Capture the accepted request for the walk and the fill answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_vpn  <= '0;
            h_off  <= '0;
            h_kind <= '0;
            h_pid  <= '0;
        end else if (fire) begin
            h_vpn  <= req_vaddr[VA_W-1:OFF_W];
            h_off  <= req_vaddr[OFF_W-1:0];
            h_kind <= req_kind;
            h_pid  <= pid_q;
        end
    end

    xlat_tag_array #(
        .N     (ENTRIES),
        .VPN_W (VPN_W),
        .PFN_W (PFN_W),
        .PID_W (PID_W)
    ) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (req_vaddr[VA_W-1:OFF_W]),
        .lk_pid    (pid_q),
        .hit       (tag_hit),
        .hit_idx   (tag_idx),
        .hit_pfn   (tag_pfn),
        .hit_flags (tag_flags),
        .flush     (flush_all),
        .wr_en     (install),
        .wr_idx    (vic_ptr),
        .wr_vpn    (h_vpn),
        .wr_pid    (h_pid),
        .wr_pfn    (fill_pfn),
        .wr_flags  (chk_out),
        .upd_en    (hit_eff && allow),
        .upd_idx   (tag_idx),
        .upd_flags (chk_out)
    );

    xlat_victim #(
        .N (ENTRIES)
    ) victim_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (install),
        .ptr   (vic_ptr)
    );

    xlat_access_check check_i (
        .kind      (chk_kind),
        .flags_in  (chk_in),
        .allow     (allow),
        .set_ref   (set_ref),
        .set_mod   (set_mod),
        .flags_out (chk_out)
    );

    // Response register: hit answer, fill answer, or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_paddr   <= '0;
            rsp_fault   <= 1'b0;
            rsp_perm    <= 1'b0;
            rsp_nocache <= 1'b0;
            rsp_upd_ref <= 1'b0;
            rsp_upd_mod <= 1'b0;
        end else if (hit_eff) begin
            rsp_valid   <= 1'b1;
            rsp_paddr   <= allow ? {tag_pfn, req_vaddr[OFF_W-1:0]} : PA_W'(0);
            rsp_fault   <= 1'b0;
            rsp_perm    <= !allow;
            rsp_nocache <= allow && tag_flags.nc;
            rsp_upd_ref <= set_ref;
            rsp_upd_mod <= set_mod;
        end else if (fill_take) begin
            rsp_valid   <= 1'b1;
            rsp_paddr   <= (fill_present && allow) ? {fill_pfn, h_off} : PA_W'(0);
            rsp_fault   <= !fill_present;
            rsp_perm    <= fill_present && !allow;
            rsp_nocache <= fill_present && allow && fill_nc;
            rsp_upd_ref <= fill_present && set_ref;
            rsp_upd_mod <= fill_present && set_mod;
        end else begin
            rsp_valid   <= 1'b0;
            rsp_paddr   <= '0;
            rsp_fault   <= 1'b0;
            rsp_perm    <= 1'b0;
            rsp_nocache <= 1'b0;
            rsp_upd_ref <= 1'b0;
            rsp_upd_mod <= 1'b0;
        end
    end

    // Walk request outputs come from the held request.
    assign walk_req_valid = (state_q == ST_WALK);
    assign walk_vpn       = h_vpn;
    assign walk_pid       = h_pid;

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !fill_valid) |=>
            (walk_req_valid && !req_ready && $stable(walk_vpn) && $stable(walk_pid)));

    // R4
    fill_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && fill_valid) |=> (rsp_valid && !walk_req_valid));

    // R2
    hit_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tag_hit && !flush_all) |=> (rsp_valid && !walk_req_valid));

    // R6
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault || rsp_perm)) |->
            (rsp_paddr == '0 && !rsp_upd_ref && !rsp_upd_mod && !rsp_nocache));

endmodule

// File: tb/xlat_tlb_tb_top.sv
// Directed bench for xlat_tlb: one task per scenario, each checking itself.
module xlat_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pid_load = 1'b0;
    logic [5:0]  pid_value = '0;
    logic        flush_all = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault, rsp_perm, rsp_nocache, rsp_upd_ref, rsp_upd_mod;
    logic        walk_req_valid;
    logic [19:0] walk_vpn;
    logic [5:0]  walk_pid;
    logic        fill_valid = 1'b0;
    logic        fill_present = 1'b0;
    logic [19:0] fill_pfn = '0;
    logic        fill_rd = 0, fill_wr = 0, fill_ex = 0, fill_nc = 0, fill_ref = 0, fill_mod = 0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    xlat_tlb dut_i (
        .clk(clk), .rst_n(rst_n), .pid_load(pid_load), .pid_value(pid_value),
        .flush_all(flush_all), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm),
        .rsp_nocache(rsp_nocache), .rsp_upd_ref(rsp_upd_ref), .rsp_upd_mod(rsp_upd_mod),
        .walk_req_valid(walk_req_valid), .walk_vpn(walk_vpn), .walk_pid(walk_pid),
        .fill_valid(fill_valid), .fill_present(fill_present), .fill_pfn(fill_pfn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_ex(fill_ex), .fill_nc(fill_nc),
        .fill_ref(fill_ref), .fill_mod(fill_mod)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request for one cycle; sample 2 ns after the edge.
    task automatic issue(input logic [31:0] va, input logic [1:0] k, input bit fl);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = k; flush_all = fl;
        @(posedge clk); #2;
        req_valid = 1'b0; flush_all = 1'b0;
    endtask

    // Walker answer beat; flags = {rd,wr,ex,nc,ref,mod}.
    task automatic serve(input bit present, input logic [19:0] pfn, input logic [5:0] fl);
        @(negedge clk);
        fill_valid = 1'b1; fill_present = present; fill_pfn = pfn;
        {fill_rd, fill_wr, fill_ex, fill_nc, fill_ref, fill_mod} = fl;
        @(posedge clk); #2;
        fill_valid = 1'b0;
    endtask

    task automatic set_pid(input logic [5:0] p);
        @(negedge clk);
        pid_load = 1'b1; pid_value = p;
        @(posedge clk); #2;
        pid_load = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(posedge clk); #2;
        flush_all = 1'b0;
    endtask

    // Miss, check the walk, then answer with a present read/write mapping.
    task automatic miss_fill(input logic [31:0] va, input logic [19:0] pfn, input string tag);
        issue(va, 2'd0, 1'b0);
        chk({tag, " walk raised"}, walk_req_valid, 1);
        chk({tag, " walk vpn"}, walk_vpn, va[31:12]);
        serve(1'b1, pfn, 6'b110000);
        chk({tag, " fill answer"}, rsp_paddr, {pfn, va[11:0]});
    endtask

    task automatic t_reset();
        chk("R12 ready", req_ready, 1);
        chk("R12 rsp_valid", rsp_valid, 0);
        chk("R12 walk", walk_req_valid, 0);
        issue(32'h0000_0000, 2'd0, 1'b0);
        chk("R12 empty after reset", walk_req_valid, 1);
        chk("R12 pid zero", walk_pid, 0);
        serve(1'b0, 20'h0, 6'b0);
    endtask

    task automatic t_miss_fill();
        issue(32'h1234_5ABC, 2'd0, 1'b0);
        chk("R3 no rsp on miss", rsp_valid, 0);
        chk("R3 walk", walk_req_valid, 1);
        chk("R3 vpn", walk_vpn, 20'h12345);
        chk("R3 pid", walk_pid, 0);
        chk("R3 stall", req_ready, 0);
        repeat (2) @(posedge clk);
        #2;
        chk("R3 held", walk_req_valid, 1);
        chk("R3 held vpn", walk_vpn, 20'h12345);
        serve(1'b1, 20'h00F0F, 6'b110000);
        chk("R4 rsp", rsp_valid, 1);
        chk("R1 paddr fill", rsp_paddr, 32'h00F0_FABC);
        chk("R4 walk dropped", walk_req_valid, 0);
        chk("R10 ref on fill", rsp_upd_ref, 1);
        chk("R10 no mod on read", rsp_upd_mod, 0);
        issue(32'h1234_5123, 2'd0, 1'b0);
        chk("R2 hit rsp", rsp_valid, 1);
        chk("R2 no walk", walk_req_valid, 0);
        chk("R1 offset passthrough", rsp_paddr, 32'h00F0_F123);
        chk("R10 ref already set", rsp_upd_ref, 0);
    endtask

    task automatic t_refmod();
        issue(32'h1234_5000, 2'd1, 1'b0);
        chk("R10 write sets mod", rsp_upd_mod, 1);
        chk("R10 write ref already", rsp_upd_ref, 0);
        issue(32'h1234_5004, 2'd1, 1'b0);
        chk("R10 second write", rsp_upd_mod, 0);
    endtask

    task automatic t_perm();
        issue(32'h1234_5000, 2'd2, 1'b0);
        chk("R6 exec denied", rsp_perm, 1);
        chk("R6 paddr zero", rsp_paddr, 0);
        issue(32'h2222_2010, 2'd1, 1'b0);
        serve(1'b1, 20'h0BEEF, 6'b100000);
        chk("R6 write on read-only", rsp_perm, 1);
        chk("R6 no mod", rsp_upd_mod, 0);
        issue(32'h2222_2010, 2'd0, 1'b0);
        chk("R6 read ok", rsp_perm, 0);
        chk("R10 ref untouched by denied access", rsp_upd_ref, 1);
        issue(32'h2222_2010, 2'd3, 1'b0);
        chk("R6 kind 3 is execute", rsp_perm, 1);
    endtask

    task automatic t_fault();
        issue(32'h3333_3000, 2'd0, 1'b0);
        serve(1'b0, 20'h01111, 6'b111000);
        chk("R5 fault", rsp_fault, 1);
        chk("R5 paddr zero", rsp_paddr, 0);
        issue(32'h3333_3000, 2'd0, 1'b0);
        chk("R5 not installed", walk_req_valid, 1);
        serve(1'b1, 20'h01111, 6'b100000);
        chk("R5 later fill ok", rsp_fault, 0);
    endtask

    task automatic t_nocache();
        issue(32'h4444_4444, 2'd0, 1'b0);
        serve(1'b1, 20'h02222, 6'b100100);
        chk("R11 nocache fill", rsp_nocache, 1);
        issue(32'h4444_4000, 2'd0, 1'b0);
        chk("R11 nocache hit", rsp_nocache, 1);
        issue(32'h1234_5000, 2'd0, 1'b0);
        chk("R11 cacheable", rsp_nocache, 0);
    endtask

    task automatic t_pid();
        set_pid(6'd5);
        issue(32'h1234_5000, 2'd0, 1'b0);
        chk("R7 other pid misses", walk_req_valid, 1);
        chk("R7 walk pid", walk_pid, 5);
        serve(1'b1, 20'h0AAAA, 6'b110000);
        set_pid(6'd0);
        issue(32'h1234_5008, 2'd0, 1'b0);
        chk("R7 pid0 survives", rsp_paddr, 32'h00F0_F008);
        set_pid(6'd5);
        issue(32'h1234_5008, 2'd0, 1'b0);
        chk("R7 pid5 hit", rsp_paddr, 32'h0AAA_A008);
    endtask

    task automatic t_flush();
        do_flush();
        issue(32'h1234_5000, 2'd0, 1'b0);
        chk("R8 flushed", walk_req_valid, 1);
        serve(1'b1, 20'h0AAAA, 6'b110000);
        issue(32'h1234_5000, 2'd0, 1'b1);
        chk("R8 flush beats lookup", walk_req_valid, 1);
        chk("R8 no hit rsp", rsp_valid, 0);
        serve(1'b1, 20'h0AAAA, 6'b110000);
    endtask

    task automatic t_victim();
        do_flush();
        for (int i = 0; i < 8; i++)
            miss_fill({20'h50000 + 20'(i), 12'h000}, 20'h00100 + 20'(i), "R9 load");
        for (int i = 0; i < 8; i++) begin
            issue({20'h50000 + 20'(i), 12'h000}, 2'd0, 1'b0);
            chk("R9 all resident", walk_req_valid, 0);
        end
        miss_fill(32'h5000_8000, 20'h00108, "R9 ninth");
        issue(32'h5000_1000, 2'd0, 1'b0);
        chk("R9 second kept", rsp_paddr, 32'h0010_1000);
        issue(32'h5000_0000, 2'd0, 1'b0);
        chk("R9 first evicted", walk_req_valid, 1);
        serve(1'b1, 20'h00100, 6'b110000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_miss_fill();
        t_refmod();
        t_perm();
        t_fault();
        t_nocache();
        t_pid();
        t_flush();
        t_victim();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule